// File: doc/BRIEF.md
# Serial LED-Driver Frame Shifter

This block turns a set of register writes into the serial pattern that a cascade of LED display driver chips expects on a three-wire link: a data line, a serial clock and an active-low load strobe. Each chip in the cascade receives a 16-bit frame. The upper byte is the register address and the lower byte is the register value.

A single-cycle `start` pulse captures one address byte and one data byte for each chip position. The block pulls the load line low and shifts out all frames back to back. It then raises load once, so that every chip in the cascade latches its frame on the same rising edge. A chip that must not change is given address 0x00, which the chips treat as a no-op. The serial clock runs at a fraction of the system clock set by a parameter. While a transfer is in progress, `busy` is high and further start requests are dropped.

Top module: `led_frame_shifter`

## Requirements
- R1: After reset, `ser_load_n` is 1, `ser_clk` is 0, `ser_dat` is 0 and `busy` is 0.
- R2: Each frame is 16 bits, sent most significant bit first. Frame bits 15..8 are the address byte and bits 7..0 are the data byte, so frame bit 15 is address bit 7.
- R3: One transaction sends CHAIN frames, which is CHAIN*16 serial clock rising edges, all under a single low period of `ser_load_n`. The frame for chain position CHAIN-1 (the bytes at `addr_in[8*CHAIN-1 -: 8]` and `data_in[8*CHAIN-1 -: 8]`) is sent first and position 0 is sent last.
- R4: `ser_clk` idles low and its high and low phases each last DIV system cycles. `ser_dat` changes only while `ser_clk` is low, so it is stable across every rising edge.
- R5: `ser_load_n` goes low on the cycle after a start is accepted. It stays low for CHAIN*32*DIV + DIV cycles and then rises once, with `ser_clk` low.
- R6: `busy` rises on the cycle after an accepted start. It falls 2*DIV cycles after `ser_load_n` rises, so load stays high for at least one serial clock period between transactions.
- R7: A `start` that arrives while `busy` is 1 is ignored. The bytes of the transfer already in progress are shifted out unchanged.
- R8: An address byte of 0x00 is sent unchanged, which gives the no-op frame {0x00, data} at that chain position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle transfer request, accepted only while idle |
| addr_in | input | 8*CHAIN | Address byte for each chain position; byte k belongs to position k |
| data_in | input | 8*CHAIN | Data byte for each chain position; byte k belongs to position k |
| busy | output | 1 | High while a transfer or the load-high hold is in progress |
| ser_clk | output | 1 | Serial clock to the cascade, idles low |
| ser_dat | output | 1 | Serial data to the first chip of the cascade |
| ser_load_n | output | 1 | Active-low load strobe; chips latch on its rising edge |

## Verification
The assertions assume that `addr_in` and `data_in` only have to be valid in the cycle where `start` is accepted. They also assume that `start` may be raised at any time, including in the middle of a transfer. The stimulus draws random address and data bytes for every chain position from a fixed seed. Between transfers it leaves random gaps of idle cycles. Directed cases cover an all-zero no-op frame, an all-ones frame, and a second start pulse raised mid-transfer with different bytes.

// File: rtl/led_frame_shifter.sv
module led_frame_shifter #(
  parameter int CHAIN = 2,
  parameter int DIV   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [8*CHAIN-1:0] addr_in,
  input  logic [8*CHAIN-1:0] data_in,
  output logic               busy,
  output logic               ser_clk,
  output logic               ser_dat,
  output logic               ser_load_n
);
  localparam int TOTAL = 16 * CHAIN;
  localparam int CW    = $clog2(2 * DIV + 1);
  localparam int BW    = $clog2(TOTAL + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_TAIL, S_HOLD} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    nbit;
  logic [TOTAL-1:0] sreg;
  logic [TOTAL-1:0] frames;

  wire [CW-1:0] lim  = (st == S_HOLD) ? CW'(2 * DIV - 1) : CW'(DIV - 1);
  wire          tick = (cnt == lim);

  always_comb begin
    frames = '0;
    for (int k = 0; k < CHAIN; k++)
      frames[16*k +: 16] = {addr_in[8*k +: 8], data_in[8*k +: 8]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      nbit <= '0;
      sreg <= '0;
    end else begin
      if (st == S_IDLE || tick) cnt <= '0;
      else                      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          sreg <= frames;
          nbit <= '0;
          st   <= S_LOW;
        end
        S_LOW:  if (tick) st <= S_HIGH;
        S_HIGH: if (tick) begin
          if (nbit == BW'(TOTAL - 1)) begin
            st <= S_TAIL;
          end else begin
            sreg <= {sreg[TOTAL-2:0], 1'b0};
            nbit <= nbit + 1'b1;
            st   <= S_LOW;
          end
        end
        S_TAIL: if (tick) st <= S_HOLD;
        S_HOLD: if (tick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign ser_clk    = (st == S_HIGH);
  assign ser_load_n = (st == S_IDLE) || (st == S_HOLD);
  assign ser_dat    = (st == S_LOW || st == S_HIGH) ? sreg[TOTAL-1] : 1'b0;
endmodule

// File: rtl/led_frame_shifter_chk.sv
module led_frame_shifter_chk #(
  parameter int CHAIN = 2,
  parameter int DIV   = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic ser_clk,
  input logic ser_dat,
  input logic ser_load_n
);
  localparam int TOTAL = 16 * CHAIN;

  int   hi_cnt;
  int   fr_cnt;
  logic clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 2 * DIV;
      fr_cnt <= 0;
      clk_q  <= 1'b0;
    end else begin
      clk_q <= ser_clk;
      if (!ser_load_n)        hi_cnt <= 0;
      else if (hi_cnt < 2 * DIV) hi_cnt <= hi_cnt + 1;
      if (ser_load_n)         fr_cnt <= 0;
      else if (ser_clk && !clk_q) fr_cnt <= fr_cnt + 1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_load_n && !ser_clk && !ser_dat)); // R1
  AST_DAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_dat)); // R4
  AST_CLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> !ser_load_n); // R5
  AST_LOAD_RISE_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_load_n) |-> !ser_clk); // R5
  AST_FRAME_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_load_n) |-> (fr_cnt == TOTAL)); // R3
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !ser_load_n)); // R6
  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_load_n) |-> (hi_cnt >= 2 * DIV)); // R6
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ser_load_n) |=> busy); // R7
endmodule

bind led_frame_shifter led_frame_shifter_chk #(.CHAIN(CHAIN), .DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_load_n(ser_load_n)
);

// File: tb/led_frame_shifter_tb.sv
`timescale 1ns/1ps
module led_frame_shifter_tb;
  localparam int CH    = 3;
  localparam int DV    = 2;
  localparam int TOTAL = 16 * CH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [8*CH-1:0] addr_in = '0;
  logic [8*CH-1:0] data_in = '0;
  logic busy, ser_clk, ser_dat, ser_load_n;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  led_frame_shifter #(.CHAIN(CH), .DIV(DV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in), .data_in(data_in),
    .busy(busy), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_load_n(ser_load_n)
  );

  function automatic logic [TOTAL-1:0] exp_stream(input logic [8*CH-1:0] a, input logic [8*CH-1:0] d);
    logic [TOTAL-1:0] s = '0;
    for (int k = CH - 1; k >= 0; k--)
      s = (s << 16) | TOTAL'({a[8*k +: 8], d[8*k +: 8]});
    return s;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic check_wide(input string req, input logic [TOTAL-1:0] act, input logic [TOTAL-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [8*CH-1:0] a, input logic [8*CH-1:0] d, input bit inject, input string tag);
    logic [TOTAL-1:0] got = '0;
    int nbits = 0, rises = 0, low_cyc = 0, hold_cyc = 0, dat_err = 0, phase_err = 0, run = 0;
    logic pclk = 1'b0, pdat = 1'b0, pload = 1'b1;
    @(negedge clk);
    addr_in = a; data_in = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 busy after start", busy, 1);
    check("R5 load low after start", ser_load_n, 0);
    pload = ser_load_n; pclk = ser_clk; pdat = ser_dat;
    low_cyc = 1;
    for (int cyc = 0; busy; cyc++) begin
      if (inject && cyc == 10) begin addr_in = ~a; data_in = ~d; start = 1'b1; end
      if (inject && cyc == 11) start = 1'b0;
      @(negedge clk);
      if (!ser_load_n) low_cyc++;
      if (ser_load_n && !pload) rises++;
      if (ser_load_n && busy) hold_cyc++;
      if (ser_load_n && !busy && !pload) hold_cyc++;
      if (ser_clk && !pclk) begin got = {got[TOTAL-2:0], ser_dat}; nbits++; end
      if (ser_clk && pclk && ser_dat != pdat) dat_err++;
      if (ser_clk) run++;
      else begin
        if (pclk && run != DV) phase_err++;
        run = 0;
      end
      pclk = ser_clk; pdat = ser_dat; pload = ser_load_n;
    end
    check_wide({tag, " stream"}, got, exp_stream(a, d));
    check("R3 bit count", nbits, TOTAL);
    check("R3 single load rise", rises, 1);
    check("R4 data change while clk high", dat_err, 0);
    check("R4 high phase length", phase_err, 0);
    check("R5 load low length", low_cyc, TOTAL * 2 * DV + DV);
    check("R6 load high hold", hold_cyc, 2 * DV);
    check("R1 idle outputs", {ser_load_n, ser_clk, ser_dat}, 3'b100);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [8*CH-1:0] ra, rd;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset load", ser_load_n, 1);
    check("R1 reset clk", ser_clk, 0);
    check("R1 reset dat", ser_dat, 0);
    check("R1 reset busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_txn(24'h00_0C_00, 24'h00_01_00, 1'b0, "R8 noop");
    run_txn('1, '1, 1'b0, "R2 ones");
    run_txn(24'h0A_0B_0C, 24'hA5_5A_3C, 1'b0, "R3 order");
    run_txn(24'h01_02_03, 24'h81_42_24, 1'b1, "R7 ignore");
    for (int i = 0; i < 30; i++) begin
      ra = 24'($urandom); rd = 24'($urandom);
      repeat ($urandom_range(0, 5)) @(negedge clk);
      run_txn(ra, rd, i % 7 == 3, "R2 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule